// File: doc/BRIEF.md
# Time Base Counter with Reference Compare Interrupts

This block keeps a free-running time base split into a low word and a high word. It advances by one on every cycle in which the tick-enable input is high, provided counting is switched on and the block is not frozen. Two reference registers are compared against the low word. A match sets a sticky status flag, and each flag has an enable bit that lets it drive a level interrupt. The interrupt leaves the block together with an 8-bit priority level taken from the control register.

Software reaches the block through a single-cycle register port. Writes take effect at the clock edge. Reads are combinational while the port is selected. The control/status register is protected by a lock that is set at reset. The lock is released only by writing the 32-bit key value 0x55CCAA33 to a separate key register, and it then stays released until the next reset. The status flags are cleared by writing 1 to them.

Top module: `timebase_cmp`

## Requirements
- R1: After reset the count is 0, the control register reads 0, both reference registers read 0, the interrupt is low and the control register is locked.
- R2: While enabled and not frozen, the count rises by exactly 1 at each clock edge where tick_i is high. A carry out of the low word (LO_W bits) increments the high word.
- R3: While the enable bit (control bit 0) is 0, the count does not change.
- R4: The count holds when the freeze-enable bit (control bit 1) and freeze_i are both 1. With either one at 0, freezing has no effect.
- R5: While the enable bit is 1, flag A (control bit 7) becomes 1 one edge after a cycle in which reference 0 equals the low word. Flag B (control bit 6) does the same for reference 1. While the enable bit is 0, no flag is set.
- R6: An unlocked control write clears each flag whose bit is written as 1. A flag written as 0 keeps its value, and both flags may be cleared in one write.
- R7: If a match and a clear of the same flag fall in the same cycle, the flag stays 1.
- R8: irq_o is high exactly when (flag A and enable A, bit 3) or (flag B and enable B, bit 2) are held. irq_level_o always equals control bits 15:8.
- R9: While locked, control writes change nothing, including flag clears. A write of any value other than 0x55CCAA33 to the key register leaves the lock as it is. Writing the key unlocks the register.
- R10: Control bits 5:4 and 31:16 always read 0.
- R11: Both reference registers can be written at any time, locked or not, and they read back the written low LO_W bits.
- R12: The register addresses are: 0 control, 1 key (reads 0), 2 reference 0, 3 reference 1, 4 count low word, 5 count high word. Other addresses read 0. Any read returns 0 unless bus_sel_i is high and bus_wr_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Count-enable strobe, one increment per high cycle |
| freeze_i | input | 1 | External freeze request |
| bus_sel_i | input | 1 | Register port select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| tb_count_o | output | LO_W+HI_W | Current time base value |
| irq_o | output | 1 | Level interrupt request |
| irq_level_o | output | 8 | Interrupt priority level |

## Verification
Register writes, key writes and tick or freeze inputs take effect at the next rising edge. So the count, the flags, the lock and the interrupt change one edge after their stimulus. A compare match reaches its flag, and from there irq_o, one edge after the cycle in which the equality held. Reads are combinational and are due within the same cycle. The bench drives inputs on the falling edge and advances its reference model on each rising edge from the values held before that edge. It compares the count, the interrupt and the level against the model on every falling edge, and it samples read data 1 ns after driving the address.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NREF   = 2;
  localparam int unsigned LVL_W  = 8;
  localparam int unsigned CTL_W  = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_KEY  = 3'd1;
  localparam logic [ADDR_W-1:0] A_REF0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd5;

  // control bit positions (LSB = 0); flag/enable of reference i at (base - i)
  localparam int B_EN    = 0;
  localparam int B_FZ    = 1;
  localparam int B_IEN0  = 3;
  localparam int B_FLG0  = 7;
  localparam int LVL_LSB = 8;
endpackage

// File: rtl/tbc_counter.sv
module tbc_counter #(
  parameter int unsigned LO_W = 32,
  parameter int unsigned HI_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv_i,
  output logic [LO_W+HI_W-1:0] cnt_o
);
  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            carry;
  logic            hi_en;

  always_comb begin
    carry = &lo_q;
    hi_en = adv_i && carry;
    lo_d  = lo_q + 1'b1;
    hi_d  = hi_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (adv_i) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  assign cnt_o = {hi_q, lo_q};
endmodule

// File: rtl/tbc_refcmp.sv
module tbc_refcmp #(
  parameter int unsigned LO_W = 32,
  parameter int unsigned NREF = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREF-1:0]           wr_i,
  input  logic [LO_W-1:0]           wdata_i,
  input  logic [LO_W-1:0]           low_i,
  output logic [NREF-1:0][LO_W-1:0] ref_o,
  output logic [NREF-1:0]           hit_o
);
  for (genvar g = 0; g < NREF; g++) begin : g_ref
    logic [LO_W-1:0] ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q <= '0;
      end else if (wr_i[g]) begin
        ref_q <= wdata_i;
      end
    end

    assign ref_o[g] = ref_q;
    assign hit_o[g] = (ref_q == low_i);
  end
endmodule

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
  import tbc_pkg::*;
#(
  parameter logic [BUS_W-1:0] KEY = 32'h55CC_AA33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_i,
  input  logic             key_wr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [NREF-1:0]  hit_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [NREF-1:0]  flag_o,
  output logic             fz_o,
  output logic             en_o,
  output logic             locked_o,
  output logic             irq_o,
  output logic [CTL_W-1:0] reg_o
);
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [NREF-1:0]  ien_q, ien_d;
  logic [NREF-1:0]  flag_q, flag_d;
  logic [NREF-1:0]  clr;
  logic             fz_q, fz_d;
  logic             en_q, en_d;
  logic             lock_q, lock_d;
  logic             ctl_ok;

  always_comb begin
    ctl_ok = ctl_wr_i && !lock_q;
    lvl_d  = lvl_q;
    ien_d  = ien_q;
    fz_d   = fz_q;
    en_d   = en_q;
    lock_d = lock_q;
    for (int i = 0; i < NREF; i++) begin
      clr[i]    = ctl_ok && wdata_i[B_FLG0-i];
      flag_d[i] = (flag_q[i] && !clr[i]) || (hit_i[i] && en_q);
    end
    if (ctl_ok) begin
      lvl_d = wdata_i[LVL_LSB +: LVL_W];
      fz_d  = wdata_i[B_FZ];
      en_d  = wdata_i[B_EN];
      for (int i = 0; i < NREF; i++) begin
        ien_d[i] = wdata_i[B_IEN0-i];
      end
    end
    if (key_wr_i && (wdata_i == KEY)) begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      ien_q <= '0;
      fz_q  <= 1'b0;
      en_q  <= 1'b0;
    end else if (ctl_ok) begin
      lvl_q <= lvl_d;
      ien_q <= ien_d;
      fz_q  <= fz_d;
      en_q  <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      lock_q <= 1'b1;
    end else begin
      flag_q <= flag_d;
      lock_q <= lock_d;
    end
  end

  always_comb begin
    reg_o = '0;
    reg_o[LVL_LSB +: LVL_W] = lvl_q;
    for (int i = 0; i < NREF; i++) begin
      reg_o[B_FLG0-i] = flag_q[i];
      reg_o[B_IEN0-i] = ien_q[i];
    end
    reg_o[B_FZ] = fz_q;
    reg_o[B_EN] = en_q;
  end

  assign lvl_o    = lvl_q;
  assign flag_o   = flag_q;
  assign fz_o     = fz_q;
  assign en_o     = en_q;
  assign locked_o = lock_q;
  assign irq_o    = |(flag_q & ien_q);
endmodule

// File: rtl/timebase_cmp.sv
module timebase_cmp
  import tbc_pkg::*;
#(
  parameter int unsigned      LO_W = 32,
  parameter int unsigned      HI_W = 32,
  parameter logic [BUS_W-1:0] KEY  = 32'h55CC_AA33
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 freeze_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [BUS_W-1:0]     bus_wdata_i,
  output logic [BUS_W-1:0]     bus_rdata_o,
  output logic [LO_W+HI_W-1:0] tb_count_o,
  output logic                 irq_o,
  output logic [LVL_W-1:0]     irq_level_o
);
  localparam int unsigned CNT_W = LO_W + HI_W;

  logic [1:0]                rs_q;
  logic                      rst_s_n;
  logic                      wr_any, ctl_wr, key_wr;
  logic [NREF-1:0]           ref_wr;
  logic [NREF-1:0][LO_W-1:0] refs;
  logic [NREF-1:0]           hits;
  logic [NREF-1:0]           flags;
  logic [CTL_W-1:0]          ctl_reg;
  logic [LVL_W-1:0]          lvl;
  logic                      en_w, fz_w, locked_w, adv;
  logic [CNT_W-1:0]          cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_s_n = rs_q[1];

  always_comb begin
    wr_any = bus_sel_i && bus_wr_i;
    ctl_wr = wr_any && (bus_addr_i == A_CTRL);
    key_wr = wr_any && (bus_addr_i == A_KEY);
    for (int i = 0; i < NREF; i++) begin
      ref_wr[i] = wr_any && (bus_addr_i == (A_REF0 + ADDR_W'(i)));
    end
    adv = tick_i && en_w && !(fz_w && freeze_i);
  end

  tbc_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .adv_i (adv),
    .cnt_o (cnt)
  );

  tbc_refcmp #(.LO_W(LO_W), .NREF(NREF)) u_ref (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_i    (ref_wr),
    .wdata_i (bus_wdata_i[LO_W-1:0]),
    .low_i   (cnt[LO_W-1:0]),
    .ref_o   (refs),
    .hit_o   (hits)
  );

  tbc_ctrl #(.KEY(KEY)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .ctl_wr_i (ctl_wr),
    .key_wr_i (key_wr),
    .wdata_i  (bus_wdata_i),
    .hit_i    (hits),
    .lvl_o    (lvl),
    .flag_o   (flags),
    .fz_o     (fz_w),
    .en_o     (en_w),
    .locked_o (locked_w),
    .irq_o    (irq_o),
    .reg_o    (ctl_reg)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_wr_i) begin
      case (bus_addr_i)
        A_CTRL:  bus_rdata_o[CTL_W-1:0] = ctl_reg;
        A_REF0:  bus_rdata_o[LO_W-1:0]  = refs[0];
        A_REF0 + 3'd1: bus_rdata_o[LO_W-1:0] = refs[1];
        A_CNTL:  bus_rdata_o[LO_W-1:0]  = cnt[LO_W-1:0];
        A_CNTH:  bus_rdata_o[HI_W-1:0]  = cnt[LO_W +: HI_W];
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign tb_count_o  = cnt;
  assign irq_level_o = lvl;
endmodule

// File: rtl/tbc_chk.sv
module tbc_chk
  import tbc_pkg::*;
#(
  parameter int unsigned      LO_W = 32,
  parameter int unsigned      HI_W = 32,
  parameter logic [BUS_W-1:0] KEY  = 32'h55CC_AA33
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic                      freeze,
  input logic                      sel,
  input logic                      wr,
  input logic [ADDR_W-1:0]         addr,
  input logic [BUS_W-1:0]          wdata,
  input logic [BUS_W-1:0]          rdata,
  input logic [LO_W+HI_W-1:0]      count,
  input logic [NREF-1:0][LO_W-1:0] refs,
  input logic [NREF-1:0]           flag,
  input logic [LVL_W-1:0]          lvl,
  input logic                      en,
  input logic                      fz,
  input logic                      locked
);
  logic ctl_w, key_ok;
  assign ctl_w  = sel && wr && (addr == A_CTRL);
  assign key_ok = sel && wr && (addr == A_KEY) && (wdata == KEY);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && !(fz && freeze)) |=> (count == $past(count) + 1'b1));

  a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fz && freeze) |=> $stable(count));

  a_r5_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    (en && refs[0] == count[LO_W-1:0]) |=> flag[0]);

  a_r5_set_b: assert property (@(posedge clk) disable iff (!rst_n)
    (en && refs[1] == count[LO_W-1:0]) |=> flag[1]);

  a_r6_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !(ctl_w && !locked && wdata[B_FLG0])) |=> flag[0]);

  a_r9_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !key_ok) |=> locked);

  a_r9_lvl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(lvl) && $stable(en));

  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr == A_CTRL) |-> (rdata[5:4] == 2'b00 && rdata[31:16] == 16'h0));
endmodule

bind timebase_cmp tbc_chk #(.LO_W(LO_W), .HI_W(HI_W), .KEY(KEY)) u_chk (
  .clk    (clk),
  .rst_n  (rst_s_n),
  .tick   (tick_i),
  .freeze (freeze_i),
  .sel    (bus_sel_i),
  .wr     (bus_wr_i),
  .addr   (bus_addr_i),
  .wdata  (bus_wdata_i),
  .rdata  (bus_rdata_o),
  .count  (tb_count_o),
  .refs   (refs),
  .flag   (flags),
  .lvl    (lvl),
  .en     (en_w),
  .fz     (fz_w),
  .locked (locked_w)
);

// File: tb/timebase_cmp_tb.sv
module timebase_cmp_tb;
  localparam int unsigned LO_W = 10;
  localparam int unsigned HI_W = 22;
  localparam int unsigned CW   = LO_W + HI_W;
  localparam logic [31:0] KEY  = 32'h55CC_AA33;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, frz = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [CW-1:0] count;
  logic          irq;
  logic [7:0]    lvl;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // reference model state
  logic [CW-1:0]   m_cnt;
  logic [LO_W-1:0] m_ref0, m_ref1;
  logic [7:0]      m_lvl;
  logic            m_fa, m_fb, m_ea, m_eb, m_fz, m_en, m_lock;

  always #5 clk = ~clk;

  timebase_cmp #(.LO_W(LO_W), .HI_W(HI_W), .KEY(KEY)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .freeze_i(frz),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .tb_count_o(count), .irq_o(irq), .irq_level_o(lvl)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_ref0 = '0; m_ref1 = '0; m_lvl = '0;
      m_fa = 0; m_fb = 0; m_ea = 0; m_eb = 0; m_fz = 0; m_en = 0; m_lock = 1;
    end else begin
      bit adv, ha, hb, wc;
      adv = tick && m_en && !(m_fz && frz);
      ha  = m_en && (m_ref0 == m_cnt[LO_W-1:0]);
      hb  = m_en && (m_ref1 == m_cnt[LO_W-1:0]);
      wc  = sel && wr && addr == 3'd0 && !m_lock;
      m_fa = (m_fa && !(wc && wdata[7])) || ha;
      m_fb = (m_fb && !(wc && wdata[6])) || hb;
      if (wc) begin
        m_lvl = wdata[15:8]; m_ea = wdata[3]; m_eb = wdata[2];
        m_fz = wdata[1]; m_en = wdata[0];
      end
      if (sel && wr && addr == 3'd1 && wdata == KEY) m_lock = 0;
      if (sel && wr && addr == 3'd2) m_ref0 = wdata[LO_W-1:0];
      if (sel && wr && addr == 3'd3) m_ref1 = wdata[LO_W-1:0];
      if (adv) m_cnt = m_cnt + 1;
    end
  end

  function automatic logic [31:0] mread(logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd0: v = {16'h0, m_lvl, m_fa, m_fb, 2'b00, m_ea, m_eb, m_fz, m_en};
      3'd2: v[LO_W-1:0] = m_ref0;
      3'd3: v[LO_W-1:0] = m_ref1;
      3'd4: v[LO_W-1:0] = m_cnt[LO_W-1:0];
      3'd5: v[HI_W-1:0] = m_cnt[CW-1:LO_W];
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(count == m_cnt, "R2 count", 64'(count), 64'(m_cnt));
      chk(irq == ((m_fa && m_ea) || (m_fb && m_eb)), "R8 irq", 64'(irq),
          64'((m_fa && m_ea) || (m_fb && m_eb)));
      chk(lvl == m_lvl, "R8 level", 64'(lvl), 64'(m_lvl));
    end
  end

  task automatic bus_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0; wdata = '0;
  endtask

  task automatic bus_rd(logic [2:0] a, string tag);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 chk(rdata == mread(a), tag, 64'(rdata), 64'(mread(a)));
    #2 sel = 0;
  endtask

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (mode == 1) ? 1'b1 : (mode == 2) ? ($urandom % 4 != 0) : 1'b0;
    end
    @(negedge clk); tick = 0;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    bus_rd(3'd0, "R1 ctrl after reset");
    bus_rd(3'd4, "R1 count low after reset");
    bus_rd(3'd2, "R1 ref0 after reset");
    chk(count == '0 && irq == 0, "R1 outputs after reset", 64'({irq, count}), 64'(0));
    // R9 locked writes ignored
    bus_wr(3'd0, 32'h0000_FF0F);
    bus_rd(3'd0, "R9 locked write ignored");
    run(5, 1);
    bus_rd(3'd4, "R3 no counting while disabled");
    bus_wr(3'd1, 32'h1234_5678);
    bus_wr(3'd0, 32'h0000_000F);
    bus_rd(3'd0, "R9 wrong key keeps lock");
    // R11 refs writable while locked
    bus_wr(3'd2, 32'd20);
    bus_wr(3'd3, 32'd40);
    bus_rd(3'd2, "R11 ref0 readback");
    bus_rd(3'd3, "R11 ref1 readback");
    bus_wr(3'd1, KEY);
    bus_wr(3'd0, 32'hFFFF_A53F);
    bus_rd(3'd0, "R10 reserved bits read zero");
    chk(rdata[5:4] == 2'b00, "R10 reserved field", 64'(rdata[5:4]), 64'(0));
    // R5 flag A
    run(25, 1);
    bus_rd(3'd0, "R5 flag A after match");
    chk(rdata[7] == 1'b1 && rdata[6] == 1'b0, "R5 flag A only", 64'(rdata[7:6]), 64'(2));
    run(20, 1);
    bus_rd(3'd0, "R5 flag B after match");
    // R6 clear A only, then both
    bus_wr(3'd0, 32'h0000_A5BF);
    bus_rd(3'd0, "R6 clear A keep B");
    chk(rdata[7:6] == 2'b01, "R6 selective clear", 64'(rdata[7:6]), 64'(1));
    bus_wr(3'd0, 32'h0000_A5CF);
    bus_rd(3'd0, "R6 clear both");
    // R8 masking
    bus_wr(3'd3, 32'(m_cnt[LO_W-1:0] + 3));
    bus_wr(3'd0, 32'h0000_5A0B);
    run(8, 1);
    chk(irq == 1'b0, "R8 masked flag B", 64'(irq), 64'(0));
    bus_wr(3'd0, 32'h0000_5A0F);
    @(negedge clk);
    chk(irq == 1'b1, "R8 enabled flag B", 64'(irq), 64'(1));
    // R4 freeze with freeze enable
    frz = 1;
    run(10, 1);
    bus_rd(3'd4, "R4 frozen count");
    // R7 set beats clear while frozen on a matching value
    bus_wr(3'd2, 32'(m_cnt[LO_W-1:0]));
    run(3, 0);
    bus_wr(3'd0, 32'h0000_5A8F);
    bus_rd(3'd0, "R7 set wins over clear");
    chk(rdata[7] == 1'b1, "R7 flag A stays", 64'(rdata[7]), 64'(1));
    bus_wr(3'd0, 32'h0000_5A0D);
    run(10, 1);
    bus_rd(3'd4, "R4 freeze input ignored without enable");
    frz = 0;
    // R3 disabled: no counting and no new flags
    bus_wr(3'd0, 32'h0000_5ACC);
    run(10, 1);
    bus_rd(3'd4, "R3 held while disabled");
    bus_rd(3'd0, "R5 no flag while disabled");
    // R2 carry into high word
    bus_wr(3'd2, 32'h0000_0300);
    bus_wr(3'd3, 32'h0000_0301);
    bus_wr(3'd0, 32'h0000_00C1);
    run(1100, 1);
    bus_rd(3'd5, "R2 carry into high word");
    chk(rdata != 0, "R2 high word nonzero", 64'(rdata), 64'(1));
    bus_rd(3'd4, "R2 low word after carry");
    // R9 non-key after unlock keeps it unlocked
    bus_wr(3'd1, 32'h0);
    bus_wr(3'd0, 32'h0000_3301);
    bus_rd(3'd0, "R9 stays unlocked");
    // R12 unused address and read gating
    bus_rd(3'd6, "R12 unused address");
    bus_rd(3'd1, "R12 key reads zero");
    @(negedge clk);
    chk(rdata == 0, "R12 no select reads zero", 64'(rdata), 64'(0));
    // mixed traffic
    bus_wr(3'd0, 32'h0000_770F);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      tick = ($urandom % 4 != 0);
      frz  = ($urandom % 5 == 0);
    end
    @(negedge clk); tick = 0; frz = 0;
    bus_rd(3'd0, "R8 ctrl after mixed traffic");
    bus_rd(3'd4, "R2 count after mixed traffic");
    repeat (2) @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule